// File: doc/BRIEF.md
# Addressed Frame Receiver with Length Field and CRC-16

This block sits behind a serial byte receiver (8 data bits, one start bit, one stop bit, no parity) on a multi-drop bus. It takes one byte per `in_valid` strobe and assembles variable-length frames. A frame starts with an address byte. The function code follows, then a payload count N, then N payload bytes, and it ends with a two-byte CRC. The header is checked byte by byte as it arrives. A frame is abandoned at its first bad header byte, so the next byte is taken as the start of a new frame. The total frame length, N + 5 bytes, comes from the count field.

Each frame that passes the CRC check is copied into an external record buffer, one byte per clock. The record holds the address byte, the count and then the payload, so downstream logic can tell which unit sent it. `frame_ok` pulses on the last write. A frame rejected after its address byte pulses `frame_err` and writes nothing. A gap between bytes that is too long in the middle of a frame also pulses `frame_err` and resets the parser.

Top module: `frame_rx`

## Requirements
- R1: After reset, `wr_en`, `frame_ok` and `frame_err` are low, and the parser takes the next byte as an address byte.
- R2: An address byte outside the inclusive range `dev_lo`..`dev_hi` is dropped without an error pulse, and the following byte is again taken as an address byte. Both range ends are accepted.
- R3: A second byte that differs from `func_code` abandons the frame, pulses `frame_err` and writes nothing.
- R4: A count byte N greater than `MAX_LEN` is a header error: the frame is dropped, `frame_err` pulses and nothing is written. N equal to `MAX_LEN` is accepted.
- R5: The CRC is CRC-16 with reflected polynomial 0xA001 and initial value 0xFFFF. It is computed over the address, function, count and payload bytes, and its low byte is sent first. A mismatch pulses `frame_err` and nothing is written.
- R6: An accepted frame is written on consecutive cycles at addresses 0 upward. Address 0 holds the address byte, address 1 holds N, and address 2+i holds payload byte i. `frame_ok` is high in the same cycle as the final write.
- R7: N = 0 is valid and produces a two-entry record.
- R8: If `GAP_CYCLES` consecutive cycles pass without a byte inside a frame, `frame_err` pulses and the parser returns to the address state. A gap of `GAP_CYCLES`-1 cycles does not abort the frame.
- R9: After any outcome, the next byte is taken as an address byte, so a good frame that directly follows a rejected one is accepted.
- R10: `frame_err` is a single-cycle pulse per rejected frame, and it is never high together with `frame_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte strobe, one cycle per byte |
| in_byte | input | 8 | Received byte |
| dev_lo | input | 8 | Lowest accepted address byte |
| dev_hi | input | 8 | Highest accepted address byte |
| func_code | input | 8 | Expected function code |
| wr_en | output | 1 | Record buffer write enable |
| wr_addr | output | $clog2(MAX_LEN+2) | Record buffer write address |
| wr_data | output | 8 | Record buffer write data |
| frame_ok | output | 1 | Frame accepted, coincides with the final write |
| frame_err | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The assertions assume that no byte arrives while an accepted record is being copied out, which takes N+2 cycles. Bytes from a real serial link are many cycles apart, so this holds on a real link. The bench keeps at least one idle cycle between bytes and waits well past `MAX_LEN`+2 cycles after each frame. It also assumes that `dev_lo` does not exceed `dev_hi` and that the range and `func_code` stay fixed within a frame. The bench sets these inputs once and never changes them.

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int MAX_LEN    = 32,
  parameter int GAP_CYCLES = 3000,
  localparam int AW = $clog2(MAX_LEN + 2),
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int GW = $clog2(GAP_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic [7:0]    dev_lo,
  input  logic [7:0]    dev_hi,
  input  logic [7:0]    func_code,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          frame_ok,
  output logic          frame_err
);

  typedef enum logic [2:0] {S_DEV, S_FUNC, S_LEN, S_PAY, S_CLO, S_CHI, S_COPY} st_t;

  st_t st;
  logic [7:0]  dev_q, len_q, pos_q, lo_q;
  logic [15:0] crc_q;
  logic [GW-1:0] gap_q;
  logic err_q;
  logic [7:0] stage [MAX_LEN];

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 16'hA001) : (x >> 1);
    return x;
  endfunction

  wire in_frame = (st != S_DEV) && (st != S_COPY);
  wire last     = (pos_q == len_q + 8'd1);
  wire [7:0] pidx = pos_q - 8'd2;

  assign wr_en     = (st == S_COPY);
  assign wr_addr   = pos_q[AW-1:0];
  assign wr_data   = (pos_q == 8'd0) ? dev_q : (pos_q == 8'd1) ? len_q : stage[pidx[IW-1:0]];
  assign frame_ok  = wr_en && last;
  assign frame_err = err_q;

  always_ff @(posedge clk)
    if (st == S_PAY && in_valid) stage[pos_q[IW-1:0]] <= in_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_DEV;
      dev_q <= '0;
      len_q <= '0;
      pos_q <= '0;
      lo_q  <= '0;
      crc_q <= 16'hFFFF;
      gap_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (st == S_COPY) begin
        pos_q <= pos_q + 8'd1;
        if (last) st <= S_DEV;
      end else if (in_valid) begin
        gap_q <= '0;
        case (st)
          S_DEV:
            if (in_byte >= dev_lo && in_byte <= dev_hi) begin
              dev_q <= in_byte;
              crc_q <= crc_step(16'hFFFF, in_byte);
              st    <= S_FUNC;
            end
          S_FUNC:
            if (in_byte == func_code) begin
              crc_q <= crc_step(crc_q, in_byte);
              st    <= S_LEN;
            end else begin
              err_q <= 1'b1;
              st    <= S_DEV;
            end
          S_LEN:
            if (int'(in_byte) > MAX_LEN) begin
              err_q <= 1'b1;
              st    <= S_DEV;
            end else begin
              len_q <= in_byte;
              crc_q <= crc_step(crc_q, in_byte);
              pos_q <= '0;
              st    <= (in_byte == 8'd0) ? S_CLO : S_PAY;
            end
          S_PAY: begin
            crc_q <= crc_step(crc_q, in_byte);
            pos_q <= pos_q + 8'd1;
            if (pos_q + 8'd1 == len_q) st <= S_CLO;
          end
          S_CLO: begin
            lo_q <= in_byte;
            st   <= S_CHI;
          end
          S_CHI:
            if ({in_byte, lo_q} == crc_q) begin
              pos_q <= '0;
              st    <= S_COPY;
            end else begin
              err_q <= 1'b1;
              st    <= S_DEV;
            end
          default: st <= S_DEV;
        endcase
      end else if (in_frame) begin
        if (gap_q == GW'(GAP_CYCLES - 1)) begin
          gap_q <= '0;
          err_q <= 1'b1;
          st    <= S_DEV;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !wr_en && !frame_err);
  p_ok_not_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));
  p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  p_first_write_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> wr_addr == '0);
  p_addr_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);
  p_ok_ends_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !wr_en);
  p_quiet_in_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_valid);
  p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_q) < GAP_CYCLES);

endmodule

// File: tb/frame_rx_tb.sv
`timescale 1ns/1ps
module frame_rx_tb;
  localparam int MAXL = 8;
  localparam int GAP  = 20;
  localparam int AW   = $clog2(MAXL + 2);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [7:0] dev_lo = 8'd4, dev_hi = 8'd9, func_code = 8'h03;
  logic wr_en, frame_ok, frame_err;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  frame_rx #(.MAX_LEN(MAXL), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .dev_lo(dev_lo), .dev_hi(dev_hi), .func_code(func_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_ok(frame_ok), .frame_err(frame_err));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int nwr = 0, nok = 0, nerr = 0, nboth = 0, nerr_hi = 0;
  logic err_prev = 1'b0;
  logic [7:0] mem [MAXL+2];
  logic [7:0] tx [MAXL+8];
  int tx_n;

  always @(negedge clk) begin
    if (wr_en) begin mem[wr_addr] = wr_data; nwr++; end
    if (frame_ok) nok++;
    if (frame_err) nerr_hi++;
    if (frame_err && !err_prev) nerr++;
    if (frame_ok && frame_err) nboth++;
    err_prev = frame_err;
  end

  function automatic logic [15:0] crc16(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c ^= {8'h00, tx[k]};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic build(input logic [7:0] dev, input logic [7:0] fn, input int n, input int seed, input bit bad_crc);
    logic [15:0] c;
    tx[0] = dev; tx[1] = fn; tx[2] = 8'(n);
    for (int i = 0; i < n; i++) tx[3+i] = 8'(seed * 7 + i * 13 + 1);
    c = crc16(n + 3);
    if (bad_crc) c ^= 16'h0100;
    tx[n+3] = c[7:0]; tx[n+4] = c[15:8];
    tx_n = n + 5;
  endtask

  task automatic send_byte(input logic [7:0] b, input int idle);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
    repeat (idle - 1) @(negedge clk);
  endtask

  task automatic push(input int count, input int stall_at, input int stall);
    for (int k = 0; k < count; k++) send_byte(tx[k], (k == stall_at) ? stall : 3);
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_rec(input string req, input int w0, input int o0, input int e0, input int n);
    chk(nok - o0 == 1, req, nok - o0, 1);
    chk(nerr - e0 == 0, req, nerr - e0, 0);
    chk(nwr - w0 == n + 2, req, nwr - w0, n + 2);
    chk(mem[0] == tx[0], req, mem[0], tx[0]);
    chk(mem[1] == 8'(n), req, mem[1], n);
    for (int i = 0; i < n; i++) chk(mem[2+i] == tx[3+i], req, mem[2+i], tx[3+i]);
  endtask

  task automatic expect_drop(input string req, input int w0, input int o0, input int e0);
    chk(nerr - e0 == 1, req, nerr - e0, 1);
    chk(nok - o0 == 0, req, nok - o0, 0);
    chk(nwr - w0 == 0, req, nwr - w0, 0);
  endtask

  task automatic t_reset();
    chk(!wr_en && !frame_ok && !frame_err, "R1", {wr_en, frame_ok, frame_err}, 0);
  endtask

  task automatic t_good();
    int w0 = nwr, o0 = nok, e0 = nerr;
    build(8'd4, 8'h03, 4, 1, 0); push(tx_n, -1, 0);
    expect_rec("R6 R5 dev_lo", w0, o0, e0, 4);
    w0 = nwr; o0 = nok; e0 = nerr;
    build(8'd9, 8'h03, 3, 2, 0); push(tx_n, -1, 0);
    expect_rec("R2 dev_hi R6", w0, o0, e0, 3);
  endtask

  task automatic t_zero_and_max();
    int w0 = nwr, o0 = nok, e0 = nerr;
    build(8'd6, 8'h03, 0, 3, 0); push(tx_n, -1, 0);
    expect_rec("R7", w0, o0, e0, 0);
    w0 = nwr; o0 = nok; e0 = nerr;
    build(8'd7, 8'h03, MAXL, 4, 0); push(tx_n, -1, 0);
    expect_rec("R4 max", w0, o0, e0, MAXL);
  endtask

  task automatic t_too_long();
    int w0 = nwr, o0 = nok, e0 = nerr;
    build(8'd5, 8'h03, 0, 0, 0); tx[2] = 8'(MAXL + 1);
    push(3, -1, 0);
    expect_drop("R4", w0, o0, e0);
  endtask

  task automatic t_bad_dev();
    int w0 = nwr, o0 = nok, e0 = nerr;
    send_byte(8'd10, 3); send_byte(8'd3, 3);
    build(8'd8, 8'h03, 2, 5, 0); push(tx_n, -1, 0);
    expect_rec("R2", w0, o0, e0, 2);
  endtask

  task automatic t_bad_func_resync();
    int w0 = nwr, o0 = nok, e0 = nerr;
    send_byte(8'd5, 3); send_byte(8'h04, 3);
    repeat (10) @(negedge clk);
    expect_drop("R3", w0, o0, e0);
    w0 = nwr; o0 = nok; e0 = nerr;
    send_byte(8'd5, 3); send_byte(8'h07, 3);
    build(8'd5, 8'h03, 3, 6, 0); push(tx_n, -1, 0);
    chk(nerr - e0 == 1, "R9", nerr - e0, 1);
    chk(nok - o0 == 1, "R9", nok - o0, 1);
    chk(nwr - w0 == 5, "R9", nwr - w0, 5);
  endtask

  task automatic t_bad_crc();
    int w0 = nwr, o0 = nok, e0 = nerr;
    build(8'd6, 8'h03, 5, 7, 1); push(tx_n, -1, 0);
    expect_drop("R5", w0, o0, e0);
  endtask

  task automatic t_timeout();
    int w0 = nwr, o0 = nok, e0 = nerr;
    build(8'd6, 8'h03, 4, 8, 0); push(tx_n, 4, GAP - 1);
    expect_rec("R8 near", w0, o0, e0, 4);
    w0 = nwr; o0 = nok; e0 = nerr;
    push(5, 4, GAP);
    expect_drop("R8 expire", w0, o0, e0);
    w0 = nwr; o0 = nok; e0 = nerr;
    build(8'd7, 8'h03, 1, 9, 0); push(tx_n, -1, 0);
    expect_rec("R8 R9 after", w0, o0, e0, 1);
  endtask

  task automatic t_pulses();
    chk(nerr_hi == nerr, "R10 width", nerr_hi, nerr);
    chk(nboth == 0, "R10 excl", nboth, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_zero_and_max();
    t_too_long();
    t_bad_dev();
    t_bad_func_resync();
    t_bad_crc();
    t_timeout();
    t_pulses();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule